// File: doc/BRIEF.md
# Stage-Grouped Pipeline Control Unit

This block is the control path of a five-stage load/store pipeline that runs a small instruction subset: register-to-register ALU operations, word load, word store, branch-if-equal and an unconditional jump. While an instruction sits in the decode stage, the block looks at its 6-bit opcode (bits 31:26) and 6-bit function field (bits 5:0). From these it builds nine control lines. Those lines are sorted into three groups, one for each stage that uses them: execute, memory access and write-back.

The groups then travel down three pipeline registers. The first register, between decode and execute, holds all three groups plus the function field. The second, between execute and memory, keeps only the memory and write-back groups, together with the ALU zero flag sampled from execute. The third, between memory and write-back, keeps only the write-back group. Each group therefore drives its own stage only. A separate bubble input per register loads that register with all-zero control, so the slot passes down the pipe as a no-operation.

The branch decision is made in the memory stage. It uses the branch bit of the instruction in that stage and the zero flag that was captured when the same instruction was in execute.

Top module: `pipe_ctrl`

## Requirements
- R1: Opcodes decode as follows, written as {reg_dst, alu_src, alu_op, mem_read, mem_write, branch, reg_write, mem_to_reg}. Opcode 0x00 (register ALU) gives 1,0,10,0,0,0,1,0. Opcode 0x23 (load) gives 0,1,00,1,0,0,1,1. Opcode 0x2B (store) gives 0,1,00,0,1,0,0,0. Opcode 0x04 (branch) gives 0,0,01,0,0,1,0,0.
- R2: The execute-group outputs (`ex_reg_dst`, `ex_alu_src`, `ex_alu_op`) show the decode of the instruction that was on `if_id_instr` at the previous rising edge, unless `bubble_ex` was high at that edge.
- R3: `ex_alu_ctl` is 0010 when alu_op is 00, and 0110 when alu_op is 01. When alu_op is 10, it follows the carried function field: 0x20 gives 0010, 0x22 gives 0110, 0x24 gives 0000, 0x25 gives 0001, 0x2A gives 0111, and any other value gives 0010.
- R4: The memory-group outputs (`mem_read`, `mem_write`, `mem_branch`) show the decode of the instruction that was in execute at the previous edge, unless `bubble_mem` was high at that edge.
- R5: `branch_taken` is high exactly when `mem_branch` is high and `ex_zero` was high at the edge where that instruction moved from execute to memory.
- R6: The write-back outputs (`wb_reg_write`, `wb_mem_to_reg`) show the decode of the instruction that was in memory at the previous edge, unless `bubble_wb` was high at that edge.
- R7: Each bubble input, when high at an edge, clears every control bit loaded into its own register, including the captured zero flag for `bubble_mem`. The other registers are not affected.
- R8: While `rst` is high at an edge, all three registers load all-zero control. After that edge every control output is 0, and `ex_alu_ctl` is 0010.
- R9: The jump opcode 0x02 and every opcode not listed in R1 decode to all-zero control.
- R10: `mem_read` and `mem_write` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| if_id_instr | input | 32 | Instruction word in decode |
| bubble_ex | input | 1 | Load a no-operation into the decode/execute register |
| bubble_mem | input | 1 | Load a no-operation into the execute/memory register |
| bubble_wb | input | 1 | Load a no-operation into the memory/write-back register |
| ex_zero | input | 1 | ALU zero flag from execute |
| ex_reg_dst | output | 1 | Destination register select (1: rd field) |
| ex_alu_src | output | 1 | ALU second operand select (1: immediate) |
| ex_alu_op | output | 2 | ALU operation class |
| ex_alu_ctl | output | 4 | Decoded ALU function |
| mem_read | output | 1 | Data memory read enable |
| mem_write | output | 1 | Data memory write enable |
| mem_branch | output | 1 | Branch instruction in memory stage |
| branch_taken | output | 1 | Branch-taken decision |
| wb_reg_write | output | 1 | Register file write enable |
| wb_mem_to_reg | output | 1 | Write-back source select (1: memory data) |

## Verification
The assertions check several invariants on every cycle. The two memory enables never fire together. A taken branch always has the branch bit set. A memory-to-register selection always comes with a register write. A bubble or reset empties the next stage. A load or branch in one stage shows up one stage further on the following cycle. Only the bench scenarios can show that every one of the 64 opcodes, over a range of function values, decodes to the right nine bits and reaches each stage at the right cycle. The same holds for the zero flag pairing with its own instruction, and for bubbles landing in one register while the neighbouring registers keep their contents.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

    localparam int INSTR_W  = 32;
    localparam int OPC_W    = 6;
    localparam int FUNCT_W  = 6;
    localparam int OPC_LSB  = INSTR_W - OPC_W;
    localparam int ALUCTL_W = 4;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'h2A;

    typedef enum logic [1:0] {
        ALUOP_ADD   = 2'b00,
        ALUOP_SUB   = 2'b01,
        ALUOP_FUNCT = 2'b10
    } alu_class_e;

    localparam logic [ALUCTL_W-1:0] ALU_AND = 4'b0000;
    localparam logic [ALUCTL_W-1:0] ALU_OR  = 4'b0001;
    localparam logic [ALUCTL_W-1:0] ALU_ADD = 4'b0010;
    localparam logic [ALUCTL_W-1:0] ALU_SUB = 4'b0110;
    localparam logic [ALUCTL_W-1:0] ALU_SLT = 4'b0111;

    typedef struct packed {
        logic       reg_dst;
        logic       alu_src;
        alu_class_e alu_op;
    } ex_grp_t;

    typedef struct packed {
        logic rd_en;
        logic wr_en;
        logic branch;
    } mem_grp_t;

    typedef struct packed {
        logic reg_wr;
        logic mem_to_reg;
    } wb_grp_t;

    typedef struct packed {
        ex_grp_t             ex;
        mem_grp_t            mem;
        wb_grp_t             wb;
        logic [FUNCT_W-1:0]  funct;
    } id_ex_t;

    typedef struct packed {
        mem_grp_t mem;
        wb_grp_t  wb;
        logic     zero;
    } ex_mem_t;

    typedef struct packed {
        wb_grp_t wb;
    } mem_wb_t;

    function automatic logic [ALUCTL_W-1:0] alu_fn_map(input logic [FUNCT_W-1:0] fn);
        logic [ALUCTL_W-1:0] r;
        case (fn)
            FN_ADD:  r = ALU_ADD;
            FN_SUB:  r = ALU_SUB;
            FN_AND:  r = ALU_AND;
            FN_OR:   r = ALU_OR;
            FN_SLT:  r = ALU_SLT;
            default: r = ALU_ADD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ctrl_main_decode.sv
module ctrl_main_decode
    import ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ex_grp_t          ex_o,
    output mem_grp_t         mem_o,
    output wb_grp_t          wb_o
);

    always_comb begin
        ex_o  = '0;
        mem_o = '0;
        wb_o  = '0;
        case (opcode)
            OPC_RTYPE: begin
                ex_o.reg_dst = 1'b1;
                ex_o.alu_op  = ALUOP_FUNCT;
                wb_o.reg_wr  = 1'b1;
            end
            OPC_LOAD: begin
                ex_o.alu_src    = 1'b1;
                ex_o.alu_op     = ALUOP_ADD;
                mem_o.rd_en     = 1'b1;
                wb_o.reg_wr     = 1'b1;
                wb_o.mem_to_reg = 1'b1;
            end
            OPC_STORE: begin
                ex_o.alu_src = 1'b1;
                ex_o.alu_op  = ALUOP_ADD;
                mem_o.wr_en  = 1'b1;
            end
            OPC_BEQ: begin
                ex_o.alu_op  = ALUOP_SUB;
                mem_o.branch = 1'b1;
            end
            OPC_JUMP: begin
                ex_o  = '0;
                mem_o = '0;
                wb_o  = '0;
            end
            default: begin
                ex_o  = '0;
                mem_o = '0;
                wb_o  = '0;
            end
        endcase
    end

endmodule

// File: rtl/ctrl_alu_decode.sv
module ctrl_alu_decode
    import ctrl_pkg::*;
(
    input  alu_class_e          alu_op,
    input  logic [FUNCT_W-1:0]  funct,
    output logic [ALUCTL_W-1:0] alu_ctl
);

    always_comb begin
        case (alu_op)
            ALUOP_ADD:   alu_ctl = ALU_ADD;
            ALUOP_SUB:   alu_ctl = ALU_SUB;
            ALUOP_FUNCT: alu_ctl = alu_fn_map(funct);
            default:     alu_ctl = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/ctrl_stage_reg.sv
module ctrl_stage_reg #(
    parameter type T = logic
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  T     d,
    output T     q
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/pipe_ctrl.sv
module pipe_ctrl
    import ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [INSTR_W-1:0]  if_id_instr,
    input  logic                bubble_ex,
    input  logic                bubble_mem,
    input  logic                bubble_wb,
    input  logic                ex_zero,
    output logic                ex_reg_dst,
    output logic                ex_alu_src,
    output logic [1:0]          ex_alu_op,
    output logic [ALUCTL_W-1:0] ex_alu_ctl,
    output logic                mem_read,
    output logic                mem_write,
    output logic                mem_branch,
    output logic                branch_taken,
    output logic                wb_reg_write,
    output logic                wb_mem_to_reg
);

    logic [OPC_W-1:0]   id_opc;
    logic [FUNCT_W-1:0] id_fn;
    logic               unused_instr_fields;

    assign id_opc = if_id_instr[INSTR_W-1:OPC_LSB];
    assign id_fn  = if_id_instr[FUNCT_W-1:0];
    assign unused_instr_fields = ^if_id_instr[OPC_LSB-1:FUNCT_W];

    ex_grp_t  id_ex_g;
    mem_grp_t id_mem_g;
    wb_grp_t  id_wb_g;

    ctrl_main_decode u_dec (
        .opcode (id_opc),
        .ex_o   (id_ex_g),
        .mem_o  (id_mem_g),
        .wb_o   (id_wb_g)
    );

    id_ex_t  idex_d,  idex_q;
    ex_mem_t exmem_d, exmem_q;
    mem_wb_t memwb_d, memwb_q;

    assign idex_d = '{ex: id_ex_g, mem: id_mem_g, wb: id_wb_g, funct: id_fn};

    ctrl_stage_reg #(.T(id_ex_t)) u_idex (
        .clk (clk),
        .rst (rst),
        .clr (bubble_ex),
        .d   (idex_d),
        .q   (idex_q)
    );

    assign exmem_d = '{mem: idex_q.mem, wb: idex_q.wb, zero: ex_zero};

    ctrl_stage_reg #(.T(ex_mem_t)) u_exmem (
        .clk (clk),
        .rst (rst),
        .clr (bubble_mem),
        .d   (exmem_d),
        .q   (exmem_q)
    );

    assign memwb_d = '{wb: exmem_q.wb};

    ctrl_stage_reg #(.T(mem_wb_t)) u_memwb (
        .clk (clk),
        .rst (rst),
        .clr (bubble_wb),
        .d   (memwb_d),
        .q   (memwb_q)
    );

    ctrl_alu_decode u_aluctl (
        .alu_op  (idex_q.ex.alu_op),
        .funct   (idex_q.funct),
        .alu_ctl (ex_alu_ctl)
    );

    assign ex_reg_dst    = idex_q.ex.reg_dst;
    assign ex_alu_src    = idex_q.ex.alu_src;
    assign ex_alu_op     = idex_q.ex.alu_op;
    assign mem_read      = exmem_q.mem.rd_en;
    assign mem_write     = exmem_q.mem.wr_en;
    assign mem_branch    = exmem_q.mem.branch;
    assign branch_taken  = exmem_q.mem.branch & exmem_q.zero;
    assign wb_reg_write  = memwb_q.wb.reg_wr;
    assign wb_mem_to_reg = memwb_q.wb.mem_to_reg;

endmodule

// File: rtl/pipe_ctrl_chk.sv
module pipe_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       bubble_ex,
    input logic       bubble_mem,
    input logic       bubble_wb,
    input logic       ex_reg_dst,
    input logic       ex_alu_src,
    input logic [1:0] ex_alu_op,
    input logic       mem_read,
    input logic       mem_write,
    input logic       mem_branch,
    input logic       branch_taken,
    input logic       wb_reg_write,
    input logic       wb_mem_to_reg
);

    // R10
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_read && mem_write));

    // R5
    taken_needs_branch_chk: assert property (@(posedge clk) disable iff (rst)
        branch_taken |-> mem_branch);

    // R6
    memsel_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        wb_mem_to_reg |-> wb_reg_write);

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> !(ex_reg_dst || ex_alu_src || (ex_alu_op != 2'b00) || mem_read
                  || mem_write || mem_branch || wb_reg_write || wb_mem_to_reg));

    // R7
    mem_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        bubble_mem |=> !(mem_read || mem_write || mem_branch || branch_taken));

    // R7
    wb_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        bubble_wb |=> !(wb_reg_write || wb_mem_to_reg));

    // R7
    ex_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        bubble_ex |=> !(ex_reg_dst || ex_alu_src || (ex_alu_op != 2'b00)));

    // R4
    beq_reaches_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_alu_op == 2'b01 && !bubble_mem) |=> mem_branch);

    // R6
    load_reaches_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_read && !bubble_wb) |=> (wb_reg_write && wb_mem_to_reg));

    // R1
    regdst_class_chk: assert property (@(posedge clk) disable iff (rst)
        ex_reg_dst |-> (ex_alu_op == 2'b10 && !ex_alu_src));

endmodule

bind pipe_ctrl pipe_ctrl_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .bubble_ex     (bubble_ex),
    .bubble_mem    (bubble_mem),
    .bubble_wb     (bubble_wb),
    .ex_reg_dst    (ex_reg_dst),
    .ex_alu_src    (ex_alu_src),
    .ex_alu_op     (ex_alu_op),
    .mem_read      (mem_read),
    .mem_write     (mem_write),
    .mem_branch    (mem_branch),
    .branch_taken  (branch_taken),
    .wb_reg_write  (wb_reg_write),
    .wb_mem_to_reg (wb_mem_to_reg)
);

// File: tb/pipe_ctrl_tb_top.sv
module pipe_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr;
    logic        b_ex, b_mem, b_wb, zf;
    logic        ex_reg_dst, ex_alu_src, mem_read, mem_write, mem_branch;
    logic        branch_taken, wb_reg_write, wb_mem_to_reg;
    logic [1:0]  ex_alu_op;
    logic [3:0]  ex_alu_ctl;

    int total = 0;
    int bad   = 0;
    string phase = "R8";

    always #10 clk = ~clk;

    pipe_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .if_id_instr   (instr),
        .bubble_ex     (b_ex),
        .bubble_mem    (b_mem),
        .bubble_wb     (b_wb),
        .ex_zero       (zf),
        .ex_reg_dst    (ex_reg_dst),
        .ex_alu_src    (ex_alu_src),
        .ex_alu_op     (ex_alu_op),
        .ex_alu_ctl    (ex_alu_ctl),
        .mem_read      (mem_read),
        .mem_write     (mem_write),
        .mem_branch    (mem_branch),
        .branch_taken  (branch_taken),
        .wb_reg_write  (wb_reg_write),
        .wb_mem_to_reg (wb_mem_to_reg)
    );

    // expected decode, {reg_dst, alu_src, alu_op[1:0], rd, wr, br, regwr, m2r} (R1, R9)
    function automatic logic [8:0] exp_dec(input logic [5:0] op);
        case (op)
            6'h00:   return 9'b1_0_10_000_10;
            6'h23:   return 9'b0_1_00_100_11;
            6'h2B:   return 9'b0_1_00_010_00;
            6'h04:   return 9'b0_0_01_001_00;
            default: return 9'b0;
        endcase
    endfunction

    // expected ALU function code (R3)
    function automatic logic [3:0] exp_alu(input logic [1:0] cls, input logic [5:0] fn);
        if (cls == 2'b01) return 4'b0110;
        if (cls != 2'b10) return 4'b0010;
        case (fn)
            6'h22:   return 4'b0110;
            6'h24:   return 4'b0000;
            6'h25:   return 4'b0001;
            6'h2A:   return 4'b0111;
            default: return 4'b0010;
        endcase
    endfunction

    // bench-side model of the three stage registers
    logic [8:0] m_ex;  logic [5:0] m_fn;
    logic [4:0] m_mem; logic m_z;
    logic [1:0] m_wb;

    always @(posedge clk) begin
        if (rst) begin
            m_ex <= '0; m_fn <= '0; m_mem <= '0; m_z <= 1'b0; m_wb <= '0;
        end else begin
            m_ex  <= b_ex  ? 9'b0 : exp_dec(instr[31:26]);
            m_fn  <= b_ex  ? 6'b0 : instr[5:0];
            m_mem <= b_mem ? 5'b0 : m_ex[4:0];
            m_z   <= b_mem ? 1'b0 : zf;
            m_wb  <= b_wb  ? 2'b0 : m_mem[1:0];
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s (%s): actual=%0h expected=%0h", tag, phase, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 reg_dst", ex_reg_dst, m_ex[8]);
        chk("R2 alu_src", ex_alu_src, m_ex[7]);
        chk("R2 alu_op",  ex_alu_op,  m_ex[6:5]);
        chk("R3 alu_ctl", ex_alu_ctl, exp_alu(m_ex[6:5], m_fn));
        chk("R4 mem grp", {mem_read, mem_write, mem_branch}, m_mem[4:2]);
        chk("R5 taken",   branch_taken, m_mem[2] & m_z);
        chk("R6 wb grp",  {wb_reg_write, wb_mem_to_reg}, m_wb);
        chk("R10 excl",   mem_read & mem_write, 0);
    endtask

    task automatic step(input logic [31:0] i, input logic be, input logic bm,
                        input logic bw, input logic z);
        @(negedge clk);
        compare_all();
        instr = i; b_ex = be; b_mem = bm; b_wb = bw; zf = z;
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [5:0] fn);
        return {op, 20'hA5C3F, fn};
    endfunction

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 100000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [5:0] fns [8] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h00, 6'h27, 6'h3F};
        rst = 1'b1; instr = mk(6'h23, 6'h20); b_ex = 0; b_mem = 0; b_wb = 0; zf = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: all control clear, ALU code is add
        chk("R8 ex", {ex_reg_dst, ex_alu_src, ex_alu_op}, 0);
        chk("R8 mem", {mem_read, mem_write, mem_branch, branch_taken}, 0);
        chk("R8 wb", {wb_reg_write, wb_mem_to_reg}, 0);
        chk("R8 alu_ctl", ex_alu_ctl, 4'b0010);
        rst = 1'b0;

        phase = "R1";
        step(mk(6'h00, 6'h22), 0, 0, 0, 0);
        step(mk(6'h23, 6'h20), 0, 0, 0, 1);
        step(mk(6'h2B, 6'h00), 0, 0, 0, 0);
        step(mk(6'h04, 6'h00), 0, 0, 0, 1);
        step(mk(6'h04, 6'h00), 0, 0, 0, 0);
        step(mk(6'h02, 6'h20), 0, 0, 0, 1);
        step(mk(6'h00, 6'h2A), 0, 0, 0, 1);
        repeat (4) step(mk(6'h3F, 6'h00), 0, 0, 0, 0);

        phase = "R9";
        for (int op = 0; op < 64; op++)
            for (int f = 0; f < 8; f++)
                step(mk(6'(op), fns[f]), 0, 0, 0, 1'((op + f) & 1));

        phase = "R7";
        for (int op = 0; op < 64; op++)
            for (int f = 0; f < 8; f++) begin
                int k = op * 8 + f;
                step(mk(6'(op), fns[f]), 1'(k % 5 == 2), 1'(k % 7 == 3),
                     1'(k % 3 == 1), 1'((k >> 1) & 1));
            end

        phase = "R8";
        @(negedge clk); rst = 1'b1;
        step(mk(6'h23, 6'h20), 0, 0, 0, 1);
        step(mk(6'h23, 6'h20), 0, 0, 0, 1);
        rst = 1'b0;
        repeat (4) step(mk(6'h04, 6'h00), 0, 0, 0, 1);
        @(negedge clk);
        compare_all();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule